// File: doc/BRIEF.md
# Cascadable fall-through FIFO

This block is a chain of dual-clock FIFO stages, each 9 bits wide by default. The stages run in first-word-fall-through fashion. A word written into an empty stage shows up on that stage's output, with its output-ready flag low, without any read. Both ready flags are active low. The output-ready flag of one stage drives the write enable of the next stage. The input-ready flag of the next stage drives the read enable of the one before it. Because of this, stages join directly and the depth of the chain is the sum of the stage depths. A word written at the head ripples forward on its own to the tail. A read at the tail opens a free slot, and that slot bubbles back to the head.

Inside each stage, the write and read pointers cross clock domains as Gray codes through two-flop synchronisers. A stage holds DEPTH words in its memory and one more word in its fall-through output register. The links between stages run on a transfer clock. A parameter selects whether that clock is the write clock or the read clock. Every clock must run freely so that words keep moving forward without reads from outside.

Top module: `fwft_chain`

## Requirements
- R1: While `rst_n` is low, `in_rdy_n` is 0 and `out_rdy_n` is 1, and both keep these values after reset is released until a word is written.
- R2: The first word written into an empty chain appears on `rd_data` with `out_rdy_n` at 0, with no read issued.
- R3: `out_rdy_n` is 0 exactly while a valid word is on `rd_data`. That word and the flag stay unchanged until the word is read. The flag returns to 1 once the chain is drained.
- R4: `in_rdy_n` is 0 while the chain has a free location. After STAGES*(DEPTH+1) words are written and none are read, `in_rdy_n` is 1.
- R5: A write with `wr_en_n` low while `in_rdy_n` is 1 is ignored. The word is never delivered, and the stored words are unchanged.
- R6: A read with `rd_en_n` low while `out_rdy_n` is 1 is ignored. Words written afterwards are all delivered, in order.
- R7: Words leave the chain in the order they were written. On every transfer-clock edge, a word leaving stage k enters stage k+1 in the same cycle.
- R8: With all clocks equal, `out_rdy_n` of an empty chain falls (STAGES-1)*4+3 clock edges after the edge that accepts the first write.
- R9: With all clocks equal, `in_rdy_n` of a full chain falls (STAGES-1)*3+2 clock edges after the edge that accepts a read at the tail.
- R10: Once up to DEPTH+1 words have settled at the tail, reads on consecutive read-clock edges each return the next word, with `out_rdy_n` staying 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock of the head stage |
| rd_clk | input | 1 | Read clock of the tail stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | WIDTH | Word to write |
| in_rdy_n | output | 1 | Active-low: the head can accept a write |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | WIDTH | Fall-through output word |
| out_rdy_n | output | 1 | Active-low: `rd_data` holds a valid word |

## Verification
The assertions assume that every clock runs freely and that reset is held low across at least one edge of each clock. They also assume that the enables and the data change away from the clock edges. The lock-step check on the links further assumes that each link is sampled on the same transfer clock that both neighbouring stages use. The stimulus drives the write and read clocks from one oscillator, so the latencies in R8 and R9 come out as exact counts. All inputs are changed on the falling edge, and reset is kept low for several cycles before the first write.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
  // Pointer width for a stage of the given depth: address bits plus a wrap bit.
  function automatic int unsigned ptr_bits(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/fwft_sync.sv
module fwft_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fwft_stage.sv
module fwft_stage #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_rdy_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_rdy_n,
  output logic             wr_fire,
  output logic             rd_fire
);
  localparam int PW = int'(fwft_pkg::ptr_bits(DEPTH));
  localparam int AW = PW - 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rgray_w;
  logic          full;

  // read domain
  logic [PW-1:0] rbin, rgray, wgray_r;
  logic          ram_has, q_valid, load;

  fwft_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
  fwft_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  assign full     = (wbin - from_gray(rgray_w)) == PW'(DEPTH);
  assign in_rdy_n = full;
  assign wr_fire  = !wr_en_n && !full;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin + PW'(1);
      wgray <= to_gray(wbin + PW'(1));
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign ram_has   = rbin != from_gray(wgray_r);
  assign rd_fire   = !rd_en_n && q_valid;
  assign load      = ram_has && (!q_valid || rd_fire);
  assign out_rdy_n = !q_valid;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      q_valid <= 1'b0;
      rd_data <= '0;
    end else if (load) begin
      rbin    <= rbin + PW'(1);
      rgray   <= to_gray(rbin + PW'(1));
      q_valid <= 1'b1;
      rd_data <= mem[rbin[AW-1:0]];
    end else if (rd_fire) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int WIDTH      = 9,
  parameter int DEPTH      = 16,
  parameter int STAGES     = 2,
  parameter bit XFER_ON_WR = 1'b0
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_rdy_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_rdy_n
);
  localparam int LAST = STAGES - 1;

  logic              xfer_clk;
  logic [STAGES-1:0] or_n, ir_n, push_v, pop_v;
  logic [WIDTH-1:0]  dat [STAGES];

  if (XFER_ON_WR) begin : g_xfer_wr
    assign xfer_clk = wr_clk;
  end else begin : g_xfer_rd
    assign xfer_clk = rd_clk;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic             s_wclk, s_rclk, s_wen_n, s_ren_n;
    logic [WIDTH-1:0] s_din;

    if (k == 0) begin : g_head
      assign s_wclk  = wr_clk;
      assign s_wen_n = wr_en_n;
      assign s_din   = wr_data;
    end else begin : g_mid_in
      assign s_wclk  = xfer_clk;
      assign s_wen_n = or_n[k-1];
      assign s_din   = dat[k-1];
    end

    if (k == LAST) begin : g_tail
      assign s_rclk  = rd_clk;
      assign s_ren_n = rd_en_n;
    end else begin : g_mid_out
      assign s_rclk  = xfer_clk;
      assign s_ren_n = ir_n[k+1];
    end

    fwft_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stage (
      .wr_clk   (s_wclk),
      .rd_clk   (s_rclk),
      .rst_n    (rst_n),
      .wr_en_n  (s_wen_n),
      .wr_data  (s_din),
      .in_rdy_n (ir_n[k]),
      .rd_en_n  (s_ren_n),
      .rd_data  (dat[k]),
      .out_rdy_n(or_n[k]),
      .wr_fire  (push_v[k]),
      .rd_fire  (pop_v[k])
    );
  end

  assign in_rdy_n  = ir_n[0];
  assign out_rdy_n = or_n[LAST];
  assign rd_data   = dat[LAST];
endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              xfer_clk,
  input logic              rst_n,
  input logic              wr_en_n,
  input logic              in_rdy_n,
  input logic              rd_en_n,
  input logic [WIDTH-1:0]  rd_data,
  input logic              out_rdy_n,
  input logic [STAGES-1:0] push_v,
  input logic [STAGES-1:0] pop_v
);
  always @(negedge rd_clk) begin
    if (!rst_n) begin
      AST_RESET_FLAGS: assert (!in_rdy_n && out_rdy_n); // R1
    end
  end

  AST_HEAD_PUSH_GATED: assert property (@(posedge wr_clk) disable iff (!rst_n)
    push_v[0] |-> (!wr_en_n && !in_rdy_n)); // R5

  AST_TAIL_POP_GATED: assert property (@(posedge rd_clk) disable iff (!rst_n)
    pop_v[STAGES-1] |-> (!rd_en_n && !out_rdy_n)); // R6

  AST_HOLD_OUTPUT: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!out_rdy_n && rd_en_n) |=> (!out_rdy_n && $stable(rd_data))); // R3

  for (genvar k = 0; k < STAGES - 1; k++) begin : g_link
    AST_LINK_LOCKSTEP: assert property (@(posedge xfer_clk) disable iff (!rst_n)
      push_v[k+1] == pop_v[k]); // R7
  end
endmodule

bind fwft_chain fwft_chain_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .xfer_clk (xfer_clk),
  .rst_n    (rst_n),
  .wr_en_n  (wr_en_n),
  .in_rdy_n (in_rdy_n),
  .rd_en_n  (rd_en_n),
  .rd_data  (rd_data),
  .out_rdy_n(out_rdy_n),
  .push_v   (push_v),
  .pop_v    (pop_v)
);

// File: tb/fwft_chain_bench.sv
module fwft_chain_bench;
  localparam int WIDTH  = 9;
  localparam int DEPTH  = 4;
  localparam int STAGES = 2;
  localparam int CAP    = STAGES * (DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_n = 1'b1;
  logic rd_en_n = 1'b1;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic in_rdy_n, out_rdy_n;

  int total = 0;
  int fails = 0;
  logic [WIDTH-1:0] exp_q [$];

  always #5 clk = ~clk;

  fwft_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(STAGES)) u_fwft_chain (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .in_rdy_n(in_rdy_n),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .out_rdy_n(out_rdy_n)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic push(input logic [WIDTH-1:0] w);
    int guard = 0;
    while (in_rdy_n && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    wr_en_n = 1'b0;
    wr_data = w;
    @(negedge clk);
    wr_en_n = 1'b1;
    exp_q.push_back(w);
  endtask

  task automatic pop_expect(input string req);
    int guard = 0;
    logic [WIDTH-1:0] e;
    while (out_rdy_n && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    e = exp_q.pop_front();
    check(req, int'(rd_data), int'(e));
    rd_en_n = 1'b0;
    @(negedge clk);
    rd_en_n = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 in_rdy_n during reset", int'(in_rdy_n), 0);
    check("R1 out_rdy_n during reset", int'(out_rdy_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in_rdy_n after release", int'(in_rdy_n), 0);
    check("R1 out_rdy_n after release", int'(out_rdy_n), 1);
  endtask

  task automatic t_fill_latency();
    int n = 0;
    logic [WIDTH-1:0] held;
    wr_en_n = 1'b0;
    wr_data = 9'h0A7;
    @(posedge clk);
    @(negedge clk);
    wr_en_n = 1'b1;
    exp_q.push_back(9'h0A7);
    while (out_rdy_n && n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check("R8 fill latency", n, (STAGES - 1) * 4 + 3);
    check("R2 fall-through word", int'(rd_data), 'h0A7);
    held = rd_data;
    repeat (6) @(negedge clk);
    check("R3 flag held without read", int'(out_rdy_n), 0);
    check("R3 word held without read", int'(rd_data), int'(held));
    pop_expect("R7 single word");
    repeat (12) @(negedge clk);
    check("R3 flag after drain", int'(out_rdy_n), 1);
  endtask

  task automatic t_ignored_read();
    rd_en_n = 1'b0;
    repeat (5) @(negedge clk);
    rd_en_n = 1'b1;
    check("R6 no word after empty reads", int'(out_rdy_n), 1);
    push(9'h155);
    push(9'h0AA);
    repeat (20) @(negedge clk);
    pop_expect("R6 first word after empty reads");
    pop_expect("R6 second word after empty reads");
    repeat (12) @(negedge clk);
    check("R6 nothing extra", int'(out_rdy_n), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 6; i++) push(WIDTH'(9'h1A5 ^ (i * 37)));
    for (int i = 0; i < 6; i++) pop_expect("R7 order");
  endtask

  task automatic t_stream();
    for (int i = 0; i < DEPTH + 1; i++) push(WIDTH'(9'h031 + i * 11));
    repeat (30) @(negedge clk);
    for (int i = 0; i < DEPTH + 1; i++) begin
      logic [WIDTH-1:0] e;
      e = exp_q.pop_front();
      check("R10 flag during stream", int'(out_rdy_n), 0);
      check("R10 streamed word", int'(rd_data), int'(e));
      rd_en_n = 1'b0;
      @(negedge clk);
    end
    rd_en_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 flag after stream", int'(out_rdy_n), 1);
  endtask

  task automatic t_full();
    int n = 0;
    logic [WIDTH-1:0] e;
    for (int i = 0; i < CAP; i++) push(WIDTH'(9'h100 + i * 5));
    repeat (40) @(negedge clk);
    check("R4 full after capacity", int'(in_rdy_n), 1);
    wr_en_n = 1'b0;
    wr_data = 9'h1FF;
    repeat (3) @(negedge clk);
    wr_en_n = 1'b1;
    check("R5 still full after refused write", int'(in_rdy_n), 1);
    e = exp_q.pop_front();
    check("R9 head of full chain", int'(rd_data), int'(e));
    rd_en_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rd_en_n = 1'b1;
    while (in_rdy_n && n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check("R9 free latency", n, (STAGES - 1) * 3 + 2);
    for (int i = 1; i < CAP; i++) pop_expect("R5 stored words intact");
    repeat (15) @(negedge clk);
    check("R5 refused word absent", int'(out_rdy_n), 1);
    check("R4 free again", int'(in_rdy_n), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_fill_latency();
    t_ignored_read();
    t_order();
    t_stream();
    t_full();
    report();
  end
endmodule